// File: doc/BRIEF.md
# Serial-Configured Clock Output Gate

This block gates a group of clock outputs one by one under control of a small configuration store that a bus master fills over a two-wire I2C link. It runs on a fast system clock, oversamples the bus clock and data lines, and finds START and STOP conditions. It acts only as a receiver: it answers one fixed 7-bit address in write mode and takes a block-write frame. That frame carries a command byte, a byte count and up to three data bytes. The data bytes land in consecutive configuration registers, starting with the first.

Each configuration bit enables one output. An enabled output follows the buffered clock input. A disabled output is driven to a steady low. A global enable input, when low, puts every output in high impedance. The outputs are modelled as a value vector plus a per-output high-impedance flag. The registers come out of reset with every output enabled, so a system that needs all outputs running never has to touch the bus.

Top module: `i2c_clk_gate`

## Requirements
- R1: After reset all three configuration registers read as 0xFF. Every output then follows `buf_clk`, with `out_hiz` low.
- R2: The block acknowledges only the address byte 0xD2, which is the 7-bit address 1101001 followed by a write bit 0. Bits are taken MSB first on rising SCL. A read bit (0xD3), the general call 0x00 and any other address get no acknowledge, and the block then ignores the bus until the next START.
- R3: `sda_pull` goes high within a few system cycles after the SCL fall that ends the eighth bit of an accepted byte. It stays high through the whole ninth SCL high phase and drops after the ninth SCL fall.
- R4: The command byte must be 0x00. Any other value is not acknowledged and nothing is written.
- R5: A byte count of 1, 2 or 3 is acknowledged. A count of 0 or above 3 is not acknowledged, and the data bytes that follow are not stored.
- R6: Data bytes are written in ascending register order from register 0. Output k (k < 16) is enabled by bit k mod 8 of register k/8. Output 16 is enabled by register 2 bit 6, and output 17 by register 2 bit 7.
- R7: Data bytes beyond the declared count are neither acknowledged nor stored.
- R8: A STOP or a repeated START in the middle of a frame ends it. Bytes already acknowledged stay written, and a partly shifted byte is dropped.
- R9: Register 2 bits 5..0 have no effect on any output.
- R10: While `glob_oe` is high, an enabled output equals `buf_clk` and a disabled output is driven low. In both cases `out_hiz` is low.
- R11: While `glob_oe` is low, every `out_hiz` bit is high and every `out_val` bit is low, whatever the registers hold. The register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| buf_clk | input | 1 | Clock to be distributed |
| glob_oe | input | 1 | Global enable; 0 puts every output in high impedance |
| out_val | output | NOUT | Driven value of each output |
| out_hiz | output | NOUT | 1 marks an output as high impedance |

## Verification
The output gating is combinational, so `out_val` and `out_hiz` are sampled one cycle after `buf_clk` or `glob_oe` moves. A written register affects the outputs about four system cycles after the SCL fall that ends its eighth bit: two synchronizer flops, one edge flop and the write flop. The bench waits ten system cycles per quarter bus bit, which is far beyond that delay. It reads the outputs only after the frame's STOP. The acknowledge is sampled just after SCL rises and again just before it falls in the ninth bit. Release is checked one quarter bit after the ninth fall. All samples are taken one time unit after a clock edge.

// File: rtl/i2c_cg_pkg.sv
package i2c_cg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_CNT,
      PH_DATA
   } phase_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("line_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign q    = chain_q[STAGES-1];
   assign rise = q & ~prev_q;
   assign fall = ~q & prev_q;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
   import i2c_cg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NREG     = 3,
   localparam int        CNTW     = $clog2(NREG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_rise,
   input  logic              sda_fall,
   output logic              sda_pull,
   output logic              wr_en,
   output logic [CNTW-1:0]   wr_idx,
   output logic [BYTE_W-1:0] wr_data
);

   phase_t              phase, nxt;
   logic [BYTE_W-1:0]   shreg;
   logic [3:0]          bitcnt;
   logic                ackph;
   logic [CNTW-1:0]     cnt_q;
   logic [CNTW-1:0]     idx;
   logic                accept;
   logic                start_evt;
   logic                stop_evt;

   assign start_evt = scl_s & sda_fall;
   assign stop_evt  = scl_s & sda_rise;

   always_comb begin
      accept = 1'b0;
      nxt    = PH_IDLE;
      case (phase)
         PH_ADDR: begin
            accept = (shreg == {DEV_ADDR, 1'b0});
            nxt    = PH_CMD;
         end
         PH_CMD: begin
            accept = (shreg == 8'h00);
            nxt    = PH_CNT;
         end
         PH_CNT: begin
            accept = (shreg != 8'h00) && (shreg <= 8'(NREG));
            nxt    = PH_DATA;
         end
         PH_DATA: begin
            accept = (idx < cnt_q);
            nxt    = PH_DATA;
         end
         default: begin
            accept = 1'b0;
            nxt    = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         shreg    <= '0;
         bitcnt   <= '0;
         ackph    <= 1'b0;
         cnt_q    <= '0;
         idx      <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_evt) begin
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            ackph    <= 1'b0;
            sda_pull <= 1'b0;
         end else if (stop_evt) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            ackph    <= 1'b0;
            sda_pull <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise && !ackph && bitcnt != 4'd8) begin
               shreg  <= {shreg[BYTE_W-2:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && ackph) begin
               sda_pull <= 1'b0;
               ackph    <= 1'b0;
               bitcnt   <= '0;
            end else if (scl_fall && bitcnt == 4'd8) begin
               if (accept) begin
                  ackph    <= 1'b1;
                  sda_pull <= 1'b1;
                  phase    <= nxt;
                  if (phase == PH_CNT) begin
                     cnt_q <= shreg[CNTW-1:0];
                     idx   <= '0;
                  end
                  if (phase == PH_DATA) begin
                     wr_en   <= 1'b1;
                     wr_idx  <= idx;
                     wr_data <= shreg;
                     idx     <= idx + CNTW'(1);
                  end
               end else begin
                  phase  <= PH_IDLE;
                  bitcnt <= '0;
               end
            end
         end
      end
   end

   // R3
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull && scl_fall) |=> !sda_pull);

   // R3
   ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(scl_fall));

   // R7
   write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sda_pull);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_pull);

   // R2
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd8);

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
   import i2c_cg_pkg::*;
#(
   parameter int  NOUT = 18,
   localparam int NREG = (NOUT + 7) / 8,
   localparam int CNTW = $clog2(NREG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CNTW-1:0]   wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [NOUT-1:0]   en
);

   localparam int LASTN = NOUT - 8 * (NREG - 1);

   logic [BYTE_W*NREG-1:0] all_q;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else if (wr_en && wr_idx == CNTW'(g)) begin
               q <= wr_data;
            end
         end
         assign all_q[g*BYTE_W +: BYTE_W] = q;
      end

      for (genvar i = 0; i < NOUT; i++) begin : g_map
         localparam int RIDX = i / 8;
         localparam int BPOS = (RIDX == NREG - 1) ? (8 - LASTN) + (i % 8) : (i % 8);
         assign en[i] = all_q[RIDX*BYTE_W + BPOS];
      end
   endgenerate

   // R1
   reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&all_q));

endmodule

// File: rtl/out_gate.sv
module out_gate #(
   parameter int NOUT = 18
) (
   input  logic [NOUT-1:0] en,
   input  logic            buf_clk,
   input  logic            glob_oe,
   output logic [NOUT-1:0] out_val,
   output logic [NOUT-1:0] out_hiz
);

   generate
      for (genvar i = 0; i < NOUT; i++) begin : g_out
         assign out_val[i] = glob_oe & en[i] & buf_clk;
         assign out_hiz[i] = ~glob_oe;
      end
   endgenerate

endmodule

// File: rtl/i2c_clk_gate.sv
module i2c_clk_gate
   import i2c_cg_pkg::*;
#(
   parameter int         NOUT        = 18,
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_in,
   input  logic            sda_in,
   output logic            sda_pull,
   input  logic            buf_clk,
   input  logic            glob_oe,
   output logic [NOUT-1:0] out_val,
   output logic [NOUT-1:0] out_hiz
);

   localparam int NREG = (NOUT + 7) / 8;
   localparam int CNTW = $clog2(NREG + 1);

   generate
      if (NOUT < 2 || NREG > 8) begin : g_bad_nout
         $error("i2c_clk_gate: NOUT out of range");
      end
   endgenerate

   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;
   logic              wr_en;
   logic [CNTW-1:0]   wr_idx;
   logic [BYTE_W-1:0] wr_data;
   logic [NOUT-1:0]   en;

   line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in),
      .q(scl_s), .rise(scl_rise), .fall(scl_fall)
   );

   line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in),
      .q(sda_s), .rise(sda_rise), .fall(sda_fall)
   );

   i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_rise(sda_rise), .sda_fall(sda_fall),
      .sda_pull(sda_pull),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   cfg_regs #(.NOUT(NOUT)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .en(en)
   );

   out_gate #(.NOUT(NOUT)) u_gate (
      .en(en), .buf_clk(buf_clk), .glob_oe(glob_oe),
      .out_val(out_val), .out_hiz(out_hiz)
   );

   // R11
   global_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_oe |-> ((&out_hiz) && (out_val == '0)));

   // R10
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_oe && !buf_clk) |-> ((out_val == '0) && (out_hiz == '0)));

endmodule

// File: tb/test_i2c_clk_gate.sv
module test_i2c_clk_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        buf_clk = 1'b1;
   logic        glob_oe = 1'b1;
   logic        sda_in;
   logic        sda_pull;
   logic [17:0] out_val;
   logic [17:0] out_hiz;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   bit  rel_bad = 1'b0;

   localparam int Q = 10;

   typedef struct packed {
      logic [7:0]  a;
      logic [7:0]  c;
      logic [7:0]  n;
      logic [7:0]  d0;
      logic [7:0]  d1;
      logic [7:0]  d2;
      logic [3:0]  nsend;
      logic [3:0]  acks;
      logic [17:0] mask;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'hD2, 8'h00, 8'h01, 8'h5A, 8'h00, 8'h00, 4'd3, 4'd4, 18'h3FF5A},
      '{8'hD2, 8'h00, 8'h03, 8'h0F, 8'h3C, 8'h40, 4'd5, 4'd6, 18'h13C0F},
      '{8'hD3, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'hFF, 4'd5, 4'd0, 18'h13C0F},
      '{8'h00, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'hFF, 4'd5, 4'd0, 18'h13C0F},
      '{8'hA4, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'hFF, 4'd5, 4'd0, 18'h13C0F},
      '{8'hD2, 8'h01, 8'h03, 8'hFF, 8'hFF, 8'hFF, 4'd5, 4'd1, 18'h13C0F},
      '{8'hD2, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 4'd3, 4'd2, 18'h13C0F},
      '{8'hD2, 8'h00, 8'h04, 8'hFF, 8'hFF, 8'hFF, 4'd5, 4'd2, 18'h13C0F},
      '{8'hD2, 8'h00, 8'h02, 8'hFF, 8'hAA, 8'h00, 4'd5, 4'd5, 18'h1AAFF},
      '{8'hD2, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'h3F, 4'd5, 4'd6, 18'h0FFFF},
      '{8'hD2, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'h80, 4'd5, 4'd6, 18'h2FFFF},
      '{8'hD2, 8'h00, 8'h03, 8'hFF, 8'hFF, 8'hC0, 4'd5, 4'd6, 18'h3FFFF}
   };
   localparam string TAGS [NV] = '{
      "R6", "R6", "R2", "R2", "R2", "R4", "R5", "R5", "R7", "R9", "R6", "R6"
   };

   assign sda_in = sda_m & ~sda_pull;

   always #2 clk = ~clk;

   i2c_clk_gate i_i2c_clk_gate (
      .clk(clk), .rst_n(rst_n),
      .scl_in(scl_m), .sda_in(sda_in), .sda_pull(sda_pull),
      .buf_clk(buf_clk), .glob_oe(glob_oe),
      .out_val(out_val), .out_hiz(out_hiz)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic bus_bit(input bit b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_byte(input logic [7:0] b, output bit ack);
      for (int k = 7; k >= 0; k--) bus_bit(b[k]);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(1);
      ack = sda_pull;
      tick(2 * Q - 2);
      ack = ack & sda_pull;
      tick(1);
      scl_m = 1'b0; tick(Q);
      if (sda_pull) rel_bad = 1'b1;
   endtask

   task automatic run_frame(input vec_t v, output int nack);
      logic [7:0] bytes [6];
      bit a;
      bytes = '{v.a, v.c, v.n, v.d0, v.d1, v.d2};
      nack = 0;
      bus_start();
      for (int k = 0; k <= int'(v.nsend); k++) begin
         bus_byte(bytes[k], a);
         if (a) nack++;
      end
      bus_stop();
      tick(Q);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int  nack;
      bit  a;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1: reset state
      chk(out_val == 18'h3FFFF, "R1 reset enables", 32'(out_val), 32'h3FFFF);
      chk(out_hiz == 18'h0, "R1 reset hiz", 32'(out_hiz), 32'h0);
      chk(sda_pull == 1'b0, "R1 reset sda idle", 32'(sda_pull), 32'h0);

      // Vector table: frames with expected acknowledge count and output mask
      for (int i = 0; i < NV; i++) begin
         run_frame(VECS[i], nack);
         chk(nack == int'(VECS[i].acks), {TAGS[i], " ack count"}, 32'(nack), 32'(VECS[i].acks));
         chk(out_val == VECS[i].mask, {TAGS[i], " output mask"}, 32'(out_val), 32'(VECS[i].mask));
      end

      // R8: STOP after one acknowledged data byte of a three-byte frame
      bus_start();
      bus_byte(8'hD2, a);
      bus_byte(8'h00, a);
      bus_byte(8'h03, a);
      bus_byte(8'h11, a);
      bus_stop();
      tick(Q);
      chk(out_val == 18'h3FF11, "R8 stop keeps acked byte", 32'(out_val), 32'h3FF11);

      // R8: repeated START inside a half-shifted byte drops it
      bus_start();
      bus_byte(8'hD2, a);
      bus_byte(8'h00, a);
      bus_byte(8'h02, a);
      bus_byte(8'h22, a);
      for (int k = 0; k < 4; k++) bus_bit(1'b0);
      bus_start();
      bus_byte(8'hD2, a);
      chk(a == 1'b1, "R8 address after repeated start", 32'(a), 32'h1);
      bus_byte(8'h00, a);
      bus_byte(8'h01, a);
      bus_byte(8'h55, a);
      bus_stop();
      tick(Q);
      chk(out_val == 18'h3FF55, "R8 partial byte dropped", 32'(out_val), 32'h3FF55);

      // R3: acknowledge released after every ninth clock
      chk(rel_bad == 1'b0, "R3 ack release", 32'(rel_bad), 32'h0);

      // R10: enabled outputs follow buf_clk, disabled ones stay low
      buf_clk = 1'b0; tick(1);
      chk(out_val == 18'h0, "R10 buf_clk low", 32'(out_val), 32'h0);
      chk(out_hiz == 18'h0, "R10 driven", 32'(out_hiz), 32'h0);
      buf_clk = 1'b1; tick(1);
      chk(out_val == 18'h3FF55, "R10 buf_clk high", 32'(out_val), 32'h3FF55);

      // R11: global enable low
      glob_oe = 1'b0; tick(1);
      chk(out_hiz == 18'h3FFFF, "R11 all hiz", 32'(out_hiz), 32'h3FFFF);
      chk(out_val == 18'h0, "R11 values low", 32'(out_val), 32'h0);
      glob_oe = 1'b1; tick(1);
      chk(out_val == 18'h3FF55, "R11 contents kept", 32'(out_val), 32'h3FF55);

      // R1: reset again restores all enables
      rst_n = 1'b0; tick(2);
      rst_n = 1'b1; tick(2);
      chk(out_val == 18'h3FFFF, "R1 second reset", 32'(out_val), 32'h3FFFF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule